// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a free-running up-counter with a compare register, a capture latch and three interrupt sources. Software starts and stops it with a control bit. It can read or overwrite the live count. It can set a timeout by writing the compare register to the current count plus a delay. Each of the three events has its own pending flag and its own enable. A single level-sensitive interrupt line reports any pending event whose enable is set.

Registers are reached over a simple word-addressed bus with a 4-bit word address. A write takes effect on the clock edge at which `bus_sel` and `bus_wr` are both high. A read is combinational from `bus_addr`. An external `cap_in` pin is synchronised inside the block, and its rising edge latches the count.

Top module: `gp_timer`

## Requirements
- R1: After reset the count, compare value, capture value, pending flags, enables and control bits are all zero, and `irq` is low.
- R2: Word 0 reads a revision byte: the major number 2 in bits [7:4] and the minor number 1 in bits [3:0], so it reads 0x21. Writes to word 0 have no effect.
- R3: While control bit 0 (word 9) is one, the count goes up by one on every clock. While that bit is zero, the count holds.
- R4: Word 10 reads the live count, and a write to word 10 replaces the count. A write to word 10 takes priority over the increment in the same cycle.
- R5: When control bit 1 is one and the count equals the compare value (word 14), pending bit 0 (word 6) is set on the next clock edge. When control bit 1 is zero, pending bit 0 is never set by a compare.
- R6: When a running count steps from all ones to zero, pending bit 1 is set on that same edge, and counting goes on from zero.
- R7: `cap_in` passes through a two-flop synchroniser. On the third rising clock edge after a low-to-high change, the count is copied into word 15 and pending bit 2 is set. A level that stays high causes no further capture.
- R8: A write to word 6 clears each pending bit whose write-data bit is one and leaves the others unchanged. Bits 0, 1 and 2 are compare, overflow and capture.
- R9: `irq` is high exactly when some pending bit is one and the enable bit in the same position of word 7 is one. Word 7 keeps only bits [2:0], and word 9 keeps only bits [1:0].
- R10: Words other than 0, 6, 7, 9, 10, 14 and 15 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data, combinational from bus_addr |
| cap_in | input | 1 | Capture trigger, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
Register writes show on the read port one nanosecond after the edge that accepts them. The count moves one step per edge while it runs. A compare flag appears one edge after the count reaches the compare value. An overflow flag appears on the very edge where the count wraps to zero. A capture lands on the third edge after the pin rises. The bench waits an exact number of edges after each stimulus and samples one nanosecond after that edge. It checks the value both one edge early and on the due edge, so a result that comes too soon or too late is reported.

// File: rtl/gp_timer.sv
module gp_timer #(
  parameter int W         = 32,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [3:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         cap_in,
  output logic         irq
);
  localparam logic [3:0] A_ID  = 4'd0;
  localparam logic [3:0] A_STS = 4'd6;
  localparam logic [3:0] A_IEN = 4'd7;
  localparam logic [3:0] A_CTL = 4'd9;
  localparam logic [3:0] A_CNT = 4'd10;
  localparam logic [3:0] A_CMP = 4'd14;
  localparam logic [3:0] A_CAP = 4'd15;
  localparam logic [7:0] REV   = {4'(REV_MAJOR), 4'(REV_MINOR)};

  logic [W-1:0] cnt_q, cmp_q, cap_q;
  logic [2:0]   sts_q, ien_q, sts_set, sts_clr;
  logic [1:0]   ctl_q;
  logic [2:0]   sync_q;
  logic         wr, cnt_wr, cap_rise, wrap, hit;

  assign wr       = bus_sel & bus_wr;
  assign cnt_wr   = wr && bus_addr == A_CNT;
  assign cap_rise = sync_q[1] & ~sync_q[2];
  assign wrap     = ctl_q[0] & ~cnt_wr & (&cnt_q);
  assign hit      = ctl_q[1] & (cnt_q == cmp_q);
  assign sts_set  = {cap_rise, wrap, hit};
  assign sts_clr  = (wr && bus_addr == A_STS) ? bus_wdata[2:0] : 3'b0;
  assign irq      = |(sts_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      cap_q  <= '0;
      sts_q  <= '0;
      ien_q  <= '0;
      ctl_q  <= '0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], cap_in};
      if (cnt_wr)        cnt_q <= bus_wdata;
      else if (ctl_q[0]) cnt_q <= cnt_q + 1'b1;
      if (cap_rise) cap_q <= cnt_q;
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (wr) begin
        case (bus_addr)
          A_IEN:   ien_q <= bus_wdata[2:0];
          A_CTL:   ctl_q <= bus_wdata[1:0];
          A_CMP:   cmp_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ID:    bus_rdata = W'(REV);
      A_STS:   bus_rdata = W'(sts_q);
      A_IEN:   bus_rdata = W'(ien_q);
      A_CTL:   bus_rdata = W'(ctl_q);
      A_CNT:   bus_rdata = cnt_q;
      A_CMP:   bus_rdata = cmp_q;
      A_CAP:   bus_rdata = cap_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(parameter int W = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         mten,
  input logic         cnt_wr,
  input logic [W-1:0] cnt,
  input logic [2:0]   sts,
  input logic [2:0]   ien,
  input logic         irq
);
  // R3
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));
  // R3
  step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> cnt == W'($past(cnt) + 1'b1));
  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr && (&cnt)) |=> (cnt == '0 && sts[1]));
  // R5
  no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mten && !sts[0]) |=> !sts[0]);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 3'b0) |-> !irq);
endmodule

bind gp_timer gp_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctl_q[0]), .mten(ctl_q[1]),
  .cnt_wr(cnt_wr), .cnt(cnt_q), .sts(sts_q), .ien(ien_q), .irq(irq));

// File: tb/test_gp_timer.sv
module test_gp_timer;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0, cap_in = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq;
  int checks = 0, errors = 0, cycles = 0;

  gp_timer i_gp_timer (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .irq(irq));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {addr, write data, expected read-back}
  localparam logic [67:0] TBL [10] = '{
    {4'd14, 32'hDEADBEEF, 32'hDEADBEEF},  // R5 compare register
    {4'd10, 32'h12345678, 32'h12345678},  // R4 counter write
    {4'd7,  32'hFFFFFFFF, 32'h00000007},  // R9 enable width
    {4'd9,  32'hFFFFFFFC, 32'h00000000},  // R9 control width
    {4'd0,  32'hFFFFFFFF, 32'h00000021},  // R2 revision
    {4'd4,  32'hFFFFFFFF, 32'h00000000},  // R10
    {4'd11, 32'hA5A5A5A5, 32'h00000000},  // R10
    {4'd13, 32'h5A5A5A5A, 32'h00000000},  // R10
    {4'd7,  32'h00000000, 32'h00000000},  // R9
    {4'd8,  32'hFFFFFFFF, 32'h00000000}   // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic edge1;
    @(posedge clk);
    #1;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    foreach (TBL[i]) begin
      if (i < 0) ;
    end
    rd(4'd10, v); chk("R1 count", v, 0);
    rd(4'd6, v);  chk("R1 status", v, 0);
    rd(4'd9, v);  chk("R1 control", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rst_n = 1;
    edge1();
    rd(4'd14, v); chk("R1 compare", v, 0);
    rd(4'd15, v); chk("R1 capture", v, 0);
    rd(4'd7, v);  chk("R1 enable", v, 0);

    for (int i = 0; i < 10; i++) begin
      wr(TBL[i][67:64], TBL[i][63:32]);
      rd(TBL[i][67:64], v);
      chk("R2/R4/R5/R9/R10 table", v, TBL[i][31:0]);
    end
    rd(4'd10, v); chk("R10 count untouched", v, 32'h12345678);

    // R3 run and hold
    wr(4'd10, 32'd100);
    wr(4'd9, 32'h1);
    repeat (5) edge1();
    rd(4'd10, v); chk("R3 running", v, 32'd105);
    wr(4'd9, 32'h0);
    rd(4'd10, v); chk("R3 stop edge", v, 32'd106);
    repeat (4) edge1();
    rd(4'd10, v); chk("R3 hold", v, 32'd106);

    // R4 write beats increment
    wr(4'd9, 32'h1);
    wr(4'd10, 32'd7);
    rd(4'd10, v); chk("R4 write over run", v, 32'd7);
    wr(4'd9, 32'h0);

    // R5 compare match timing
    wr(4'd10, 32'd50);
    wr(4'd14, 32'd55);
    wr(4'd7, 32'h1);
    wr(4'd9, 32'h3);
    repeat (5) edge1();
    rd(4'd6, v); chk("R5 early", v, 0);
    chk("R9 irq early", {31'b0, irq}, 0);
    edge1();
    rd(4'd6, v); chk("R5 due", v, 32'h1);
    chk("R9 irq match", {31'b0, irq}, 1);
    wr(4'd9, 32'h0);
    wr(4'd6, 32'h1);
    rd(4'd6, v); chk("R8 clear match", v, 0);
    chk("R9 irq cleared", {31'b0, irq}, 0);

    // R5 compare disabled
    wr(4'd10, 32'd50);
    wr(4'd9, 32'h1);
    repeat (10) edge1();
    wr(4'd9, 32'h0);
    rd(4'd6, v); chk("R5 disabled", v, 0);

    // R6 overflow
    wr(4'd10, 32'hFFFFFFFE);
    wr(4'd9, 32'h1);
    edge1();
    rd(4'd6, v); chk("R6 before wrap", v, 0);
    rd(4'd10, v); chk("R6 all ones", v, 32'hFFFFFFFF);
    edge1();
    rd(4'd6, v); chk("R6 flag", v, 32'h2);
    rd(4'd10, v); chk("R6 zero", v, 0);
    edge1();
    rd(4'd10, v); chk("R6 continues", v, 32'd1);
    wr(4'd9, 32'h0);

    // R7 capture
    wr(4'd10, 32'h1000);
    @(negedge clk); cap_in = 1;
    edge1(); edge1();
    rd(4'd6, v); chk("R7 early", v, 32'h2);
    edge1();
    rd(4'd6, v); chk("R7 flag", v, 32'h6);
    rd(4'd15, v); chk("R7 value", v, 32'h1000);
    wr(4'd10, 32'h2000);
    repeat (5) edge1();
    rd(4'd15, v); chk("R7 level no recapture", v, 32'h1000);

    // R8 partial clear, R9 enables
    wr(4'd6, 32'h2);
    rd(4'd6, v); chk("R8 partial", v, 32'h4);
    wr(4'd7, 32'h3);
    chk("R9 masked", {31'b0, irq}, 0);
    wr(4'd7, 32'h4);
    chk("R9 enabled", {31'b0, irq}, 1);
    wr(4'd6, 32'h0);
    rd(4'd6, v); chk("R8 zero write keeps", v, 32'h4);
    wr(4'd6, 32'h7);
    rd(4'd6, v); chk("R8 clear all", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule